// File: doc/BRIEF.md
# Synchronous Clock Prescaler and Gating

This block derives every synchronous clock domain from a single main clock. The main clock is taken from one of several source inputs. Each source is a clock-enable stream plus a ready flag, and the selected stream's pulses are the "main ticks". One 8-bit tick counter is shared by all domains and acts as a power-of-two prescaler. The CPU and high-speed bus domains share one divider setting, and each peripheral bus has its own. Every domain output is a one-cycle clock-enable pulse, and every module inside a domain has its own enable that a per-module mask can silence.

Software writes the source, divider and mask fields through a simple register write port. Source and divider changes are held pending and move into effect only at the point where the shared count wraps. At that point every divided domain has just finished a full period, so no period is ever cut short. A request for a source that is not ready is refused and latches an error flag. While the sleep input is high, all domain and module enables stay low, but the prescaler keeps counting so its phase is kept.

Top module: `clkgen_sync_top`

## Requirements
- R1: After reset, `dom_en`, `mod_en` and `cfg_err` are low. Source 0 drives the main tick, every domain is undivided, every module mask bit is open, and the tick count is 0.
- R2: With its divide bit at 0, a domain's `dom_en` bit is high for exactly the cycle that follows each clock edge at which the active source's `src_tick` bit is sampled high and `sleep_in` is sampled low.
- R3: With its divide bit (data bit 3) at 1 and select field (data bits 2:0) at s, a domain pulses only on main ticks where the low s+1 bits of the tick count are all ones. The count starts at 0, advances by one per main tick and wraps from 255 to 0, so the domain pulses once every 2^(s+1) main ticks.
- R4: Register address 1 holds the one setting used by both CPU (`dom_en[0]`) and high-speed bus (`dom_en[1]`), so those two outputs are always identical. Address 2+k holds the setting for peripheral bus k (`dom_en[2+k]`).
- R5: A write to address 0 with data bits 1:0 naming a source whose `src_ready` bit is high makes that source the pending main-tick source.
- R6: A write to address 0 that names a source whose `src_ready` bit is low leaves the pending source unchanged. It sets `cfg_err`, which stays high until reset.
- R7: Pending source and divider values become active only at a clock edge that samples a main tick with the count at 255. The enables produced at that edge still follow the old settings. A write sampled at that same edge waits for the next wrap.
- R8: Address 4+d holds the mask of domain d. While bit m of that mask is 1, `mod_en[d*4+m]` equals `dom_en[d]`; while it is 0, that output stays low. A mask write affects the enables from the following edge on.
- R9: While `sleep_in` is sampled high, no `dom_en` or `mod_en` bit pulses, but the tick count keeps advancing on main ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all sources are enables in this domain |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Per-source clock-enable streams |
| src_ready | input | 4 | Per-source ready flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 source, 1 CPU/HSB, 2..3 peripheral buses, 4..7 masks) |
| wr_data | input | 4 | Register write data |
| sleep_in | input | 1 | Shuts all domains while high |
| dom_en | output | 4 | Domain enable pulses: CPU, HSB, PB0, PB1 |
| mod_en | output | 16 | Module enable pulses, four per domain |
| cfg_err | output | 1 | Sticky refused-source-switch flag |

## Verification
A register write and the wrap-point commit can be sampled at the same edge, and sleep can cover a commit. The bench provokes both with thousands of cycles of random writes, random sleep and source ticks of different rates. Each cycle it compares every output against a behavioural model. In the model, a write seen at the wrap edge is stored but stays pending until the next wrap. A commit under sleep still switches settings, even though no enable pulses at that edge.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Width of the divider select field; the prescaler counter spans 2^SELW bits.
    localparam int unsigned CG_SELW = 3;
    localparam int unsigned CG_PSW  = 1 << CG_SELW;

    typedef struct packed {
        logic                div;
        logic [CG_SELW-1:0]  sel;
    } div_cfg_t;

    localparam div_cfg_t CG_CFG_RESET = '{div: 1'b0, sel: '0};

    function automatic int unsigned cg_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // True when a domain with this setting pulses on a main tick at count cnt.
    function automatic logic period_hit(logic [CG_PSW-1:0] cnt, div_cfg_t cfg);
        logic hit;
        hit = 1'b1;
        if (cfg.div) begin
            for (int b = 0; b < int'(CG_PSW); b++) begin
                if (b <= int'(cfg.sel) && !cnt[b]) begin
                    hit = 1'b0;
                end
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter int unsigned NSRC      = 4,
    parameter int unsigned NGRP      = 3,
    parameter int unsigned ND        = 4,
    parameter int unsigned NMOD      = 4,
    parameter int unsigned ADDRW     = 3,
    parameter int unsigned DATAW     = 4,
    parameter int unsigned SRCW      = 2,
    parameter int unsigned MASK_BASE = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDRW-1:0]        wr_addr,
    input  logic [DATAW-1:0]        wr_data,
    input  logic [NSRC-1:0]         src_ready,
    output logic [SRCW-1:0]         pend_src,
    output div_cfg_t [NGRP-1:0]     pend_cfg,
    output logic [ND*NMOD-1:0]      mod_on,
    output logic                    cfg_err
);

    logic src_ok;

    // Requested source must exist and be ready.
    always_comb begin
        src_ok = 1'b0;
        for (int s = 0; s < int'(NSRC); s++) begin
            if (wr_data[SRCW-1:0] == SRCW'(s)) begin
                src_ok = src_ready[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_src <= '0;
            pend_cfg <= {NGRP{CG_CFG_RESET}};
            mod_on   <= '1;
            cfg_err  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDRW'(0)) begin
                if (src_ok) begin
                    pend_src <= wr_data[SRCW-1:0];
                end else begin
                    cfg_err <= 1'b1;
                end
            end
            for (int g = 0; g < int'(NGRP); g++) begin
                if (wr_addr == ADDRW'(1 + g)) begin
                    pend_cfg[g] <= div_cfg_t'(wr_data[CG_SELW:0]);
                end
            end
            for (int d = 0; d < int'(ND); d++) begin
                if (wr_addr == ADDRW'(MASK_BASE + d)) begin
                    mod_on[d*NMOD +: NMOD] <= wr_data[NMOD-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/clkgen_presc.sv
module clkgen_presc
    import clkgen_pkg::*;
#(
    parameter int unsigned NSRC = 4,
    parameter int unsigned NGRP = 3,
    parameter int unsigned SRCW = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         src_tick,
    input  logic [SRCW-1:0]         pend_src,
    input  div_cfg_t [NGRP-1:0]     pend_cfg,
    output logic                    main_tick,
    output logic [CG_PSW-1:0]       cnt,
    output div_cfg_t [NGRP-1:0]     act_cfg
);

    logic [SRCW-1:0] act_src;
    logic            commit;

    always_comb begin
        main_tick = 1'b0;
        for (int s = 0; s < int'(NSRC); s++) begin
            if (act_src == SRCW'(s)) begin
                main_tick = src_tick[s];
            end
        end
    end

    // Every divided period ends together when the count wraps.
    assign commit = main_tick && (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_src <= '0;
            act_cfg <= {NGRP{CG_CFG_RESET}};
            cnt     <= '0;
        end else if (main_tick) begin
            cnt <= cnt + 1'b1;
            if (commit) begin
                act_src <= pend_src;
                act_cfg <= pend_cfg;
            end
        end
    end

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate
    import clkgen_pkg::*;
#(
    parameter int unsigned ND   = 4,
    parameter int unsigned NMOD = 4,
    parameter int unsigned NGRP = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    main_tick,
    input  logic [CG_PSW-1:0]       cnt,
    input  div_cfg_t [NGRP-1:0]     act_cfg,
    input  logic                    sleep_in,
    input  logic [ND*NMOD-1:0]      mod_on,
    output logic [ND-1:0]           dom_en,
    output logic [ND*NMOD-1:0]      mod_en
);

    logic [ND-1:0] hit;
    logic [ND-1:0] fire;

    // Domains 0 and 1 share group 0; peripheral bus k uses group k+1.
    for (genvar d = 0; d < int'(ND); d++) begin : g_dom
        localparam int unsigned GRP = (d < 2) ? 0 : d - 1;
        assign hit[d] = period_hit(cnt, act_cfg[GRP]);
    end

    assign fire = hit & {ND{main_tick & ~sleep_in}};

    always_ff @(posedge clk) begin
        if (rst) begin
            dom_en <= '0;
            mod_en <= '0;
        end else begin
            dom_en <= fire;
            for (int d = 0; d < int'(ND); d++) begin
                mod_en[d*NMOD +: NMOD] <= {NMOD{fire[d]}} & mod_on[d*NMOD +: NMOD];
            end
        end
    end

endmodule

// File: rtl/clkgen_sync_top.sv
module clkgen_sync_top
    import clkgen_pkg::*;
#(
    parameter  int unsigned NSRC      = 4,
    parameter  int unsigned NPB       = 2,
    parameter  int unsigned NMOD      = 4,
    localparam int unsigned ND        = 2 + NPB,
    localparam int unsigned NGRP      = 1 + NPB,
    localparam int unsigned MASK_BASE = 1 + NGRP,
    localparam int unsigned ADDRW     = $clog2(MASK_BASE + ND),
    localparam int unsigned SRCW      = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int unsigned DATAW     = cg_max(cg_max(NMOD, CG_SELW + 1), SRCW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_tick,
    input  logic [NSRC-1:0]      src_ready,
    input  logic                 wr_en,
    input  logic [ADDRW-1:0]     wr_addr,
    input  logic [DATAW-1:0]     wr_data,
    input  logic                 sleep_in,
    output logic [ND-1:0]        dom_en,
    output logic [ND*NMOD-1:0]   mod_en,
    output logic                 cfg_err
);

    logic [SRCW-1:0]        pend_src;
    div_cfg_t [NGRP-1:0]    pend_cfg;
    div_cfg_t [NGRP-1:0]    act_cfg;
    logic [ND*NMOD-1:0]     mod_on;
    logic                   main_tick;
    logic [CG_PSW-1:0]      cnt;

    clkgen_regs #(
        .NSRC(NSRC), .NGRP(NGRP), .ND(ND), .NMOD(NMOD),
        .ADDRW(ADDRW), .DATAW(DATAW), .SRCW(SRCW), .MASK_BASE(MASK_BASE)
    ) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_ready(src_ready),
        .pend_src(pend_src), .pend_cfg(pend_cfg),
        .mod_on(mod_on), .cfg_err(cfg_err)
    );

    clkgen_presc #(
        .NSRC(NSRC), .NGRP(NGRP), .SRCW(SRCW)
    ) presc_i (
        .clk(clk), .rst(rst),
        .src_tick(src_tick), .pend_src(pend_src), .pend_cfg(pend_cfg),
        .main_tick(main_tick), .cnt(cnt), .act_cfg(act_cfg)
    );

    clkgen_gate #(
        .ND(ND), .NMOD(NMOD), .NGRP(NGRP)
    ) gate_i (
        .clk(clk), .rst(rst),
        .main_tick(main_tick), .cnt(cnt), .act_cfg(act_cfg),
        .sleep_in(sleep_in), .mod_on(mod_on),
        .dom_en(dom_en), .mod_en(mod_en)
    );

endmodule

// File: rtl/clkgen_sync_chk.sv
module clkgen_sync_chk #(
    parameter int unsigned NSRC = 4,
    parameter int unsigned ND   = 4,
    parameter int unsigned NMOD = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NSRC-1:0]      src_tick,
    input logic                 sleep_in,
    input logic [ND-1:0]        dom_en,
    input logic [ND*NMOD-1:0]   mod_en,
    input logic                 cfg_err
);

    // R1: first cycle out of reset shows no enables and no error
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dom_en == '0 && mod_en == '0 && !cfg_err));

    // R2: no source pulse in the previous cycle means no domain pulse now
    a_r2_no_tick_no_pulse: assert property (@(posedge clk) disable iff (rst)
        ($past(src_tick) == '0) |-> (dom_en == '0));

    // R4: CPU and high-speed bus share one divider setting
    a_r4_shared_setting: assert property (@(posedge clk) disable iff (rst)
        dom_en[0] == dom_en[1]);

    // R6: error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_err) |-> cfg_err);

    // R9: sleep sampled at the last edge suppresses every enable
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_in) |-> (dom_en == '0 && mod_en == '0));

    // R8: a module enable never fires outside its domain pulse
    for (genvar i = 0; i < int'(ND * NMOD); i++) begin : g_mod
        a_r8_mod_within_dom: assert property (@(posedge clk) disable iff (rst)
            mod_en[i] |-> dom_en[i / NMOD]);
    end

endmodule

bind clkgen_sync_top clkgen_sync_chk #(
    .NSRC(NSRC), .ND(ND), .NMOD(NMOD)
) chk_i (
    .clk(clk), .rst(rst), .src_tick(src_tick), .sleep_in(sleep_in),
    .dom_en(dom_en), .mod_en(mod_en), .cfg_err(cfg_err)
);

// File: tb/clkgen_sync_top_tb_top.sv
`timescale 1ns/1ps
module clkgen_sync_top_tb_top;

    localparam int NSRC = 4;
    localparam int NPB  = 2;
    localparam int NMOD = 4;
    localparam int ND   = NPB + 2;
    localparam int NGRP = NPB + 1;
    localparam int MB   = NGRP + 1;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NSRC-1:0]      src_tick;
    logic [NSRC-1:0]      src_ready;
    logic                 wr_en;
    logic [2:0]           wr_addr;
    logic [3:0]           wr_data;
    logic                 sleep_in;
    logic [ND-1:0]        dom_en;
    logic [ND*NMOD-1:0]   mod_en;
    logic                 cfg_err;

    always #2 clk = ~clk;

    clkgen_sync_top #(.NSRC(NSRC), .NPB(NPB), .NMOD(NMOD)) dut_i (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_ready(src_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sleep_in(sleep_in), .dom_en(dom_en), .mod_en(mod_en), .cfg_err(cfg_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycn  = 0;
    string tag = "R1";

    // ---------------- behavioural reference model ----------------
    int  m_cnt, m_src, m_psrc;
    int  m_en[NGRP], m_sel[NGRP], p_en[NGRP], p_sel[NGRP];
    bit  m_mask[ND][NMOD];
    bit  m_err;
    logic [ND-1:0]      e_dom;
    logic [ND*NMOD-1:0] e_mod;
    logic               e_err;
    string              e_tag;
    bit                 started = 0;

    always @(posedge clk) begin
        int g, per, a;
        bit tick, hit, f;
        if (rst) begin
            m_cnt = 0; m_src = 0; m_psrc = 0; m_err = 0;
            for (int k = 0; k < NGRP; k++) begin
                m_en[k] = 0; m_sel[k] = 0; p_en[k] = 0; p_sel[k] = 0;
            end
            for (int d = 0; d < ND; d++)
                for (int m = 0; m < NMOD; m++) m_mask[d][m] = 1;
            e_dom = '0; e_mod = '0; e_err = 0;
        end else begin
            tick = src_tick[m_src];
            for (int d = 0; d < ND; d++) begin
                g   = (d < 2) ? 0 : d - 1;
                per = 2 ** (m_sel[g] + 1);
                hit = (m_en[g] == 0) || ((m_cnt % per) == per - 1);
                f   = tick && hit && !sleep_in;
                e_dom[d] = f;
                for (int m = 0; m < NMOD; m++) e_mod[d*NMOD+m] = f && m_mask[d][m];
            end
            if (tick) begin
                if (m_cnt == 255) begin
                    m_cnt = 0;
                    m_src = m_psrc;
                    for (int k = 0; k < NGRP; k++) begin
                        m_en[k] = p_en[k]; m_sel[k] = p_sel[k];
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (wr_en) begin
                a = int'(wr_addr);
                if (a == 0) begin
                    if (src_ready[wr_data[1:0]]) m_psrc = int'(wr_data[1:0]);
                    else m_err = 1;
                end else if (a <= NGRP) begin
                    p_en[a-1]  = int'(wr_data[3]);
                    p_sel[a-1] = int'(wr_data[2:0]);
                end else if (a < MB + ND) begin
                    for (int m = 0; m < NMOD; m++) m_mask[a-MB][m] = wr_data[m];
                end
            end
            e_err = m_err;
        end
        e_tag   = tag;
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp++;
            if (dom_en !== e_dom || mod_en !== e_mod || cfg_err !== e_err) begin
                n_bad++;
                $display("FAIL %s cycle %0d: dom_en=%b mod_en=%b err=%b expected dom_en=%b mod_en=%b err=%b",
                         e_tag, cycn, dom_en, mod_en, cfg_err, e_dom, e_mod, e_err);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cycn++;
        src_tick[0] = 1'b1;
        src_tick[1] = (cycn % 2) == 0;
        src_tick[2] = (cycn % 3) == 0;
        src_tick[3] = 1'($urandom % 2);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc();
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 4'(d);
    endtask

    task automatic count_pulses(input int bitidx, input bit is_mod, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (is_mod) c += int'(mod_en[bitidx]);
            else        c += int'(dom_en[bitidx]);
        end
    endtask

    initial begin
        int c;
        rst = 1'b1; src_tick = '0; src_ready = 4'b0111;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; sleep_in = 1'b0;
        repeat (4) cyc();
        rst = 1'b0;
        repeat (3) cyc();
        chk(cfg_err == 1'b0, "R1 error flag after reset", int'(cfg_err), 0);

        tag = "R2";
        count_pulses(3, 0, 32, c);
        chk(c == 32, "R2 undivided PB1 pulses in 32 cycles", c, 32);

        tag = "R4";
        wr(1, 4'b1001);   // CPU/HSB divide by 4
        wr(2, 4'b1000);   // PB0 divide by 2
        wr(3, 4'b1010);   // PB1 divide by 8
        tag = "R7";
        repeat (300) cyc();
        tag = "R3";
        count_pulses(3, 0, 64, c);
        chk(c == 8, "R3 PB1 divide-by-8 pulses in 64 cycles", c, 8);
        count_pulses(2, 0, 64, c);
        chk(c == 32, "R3 PB0 divide-by-2 pulses in 64 cycles", c, 32);
        count_pulses(0, 0, 64, c);
        chk(c == 16, "R4 CPU divide-by-4 pulses in 64 cycles", c, 16);

        tag = "R8";
        wr(MB + 2, 4'b0101);
        repeat (4) cyc();
        count_pulses(2*NMOD + 1, 1, 32, c);
        chk(c == 0, "R8 masked module pulses", c, 0);
        count_pulses(2*NMOD + 0, 1, 32, c);
        chk(c == 16, "R8 open module pulses", c, 16);

        tag = "R6";
        wr(0, 3);
        cyc();
        chk(cfg_err == 1'b1, "R6 error after not-ready select", int'(cfg_err), 1);
        repeat (300) cyc();
        count_pulses(2, 0, 64, c);
        chk(c == 32, "R6 source unchanged after refused select", c, 32);

        tag = "R5";
        wr(0, 1);
        repeat (600) cyc();
        count_pulses(2, 0, 64, c);
        chk(c == 16, "R5 PB0 on half-rate source", c, 16);
        chk(cfg_err == 1'b1, "R6 error stays set", int'(cfg_err), 1);

        tag = "R9";
        cyc();
        sleep_in = 1'b1;
        c = 0;
        for (int i = 0; i < 40; i++) begin
            cyc();
            c += $countones({dom_en, mod_en});
        end
        chk(c == 0, "R9 enables during sleep", c, 0);
        sleep_in = 1'b0;

        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            cyc();
            if ($urandom % 10 == 0) begin
                wr_en   = 1'b1;
                wr_addr = 3'($urandom % 8);
                wr_data = 4'($urandom % 16);
            end
            sleep_in     = ($urandom % 8) == 0;
            src_ready[2] = ($urandom % 4) != 0;
        end
        cyc();
        cyc();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule